// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash-style memory. It decides when an embedded program or erase operation has ended. After a start pulse it reads the device status in pairs and compares the toggle bit (data bit 6) between the two reads of each pair. Equal values mean the operation has finished. A changed value means the device is still busy. In that case the timeout flag (data bit 5) of the second read decides what happens next.

A raised flag does not prove failure, because the toggle bit may stop in the same cycle the flag rises. So the poller runs exactly one more pair before it judges. If toggling persists through that re-check pair, the poller writes a reset command to return the device to array reads and reports an error. A parameter caps the number of pairs. Hitting the cap gives a host-side timeout error, and no write is issued in that case.

Read requests use a valid/ready channel. The valid signal is held, with no other change, until ready is seen. The response channel has no ready: the poller accepts one response per request, in any cycle after the request is taken, and ignores a response it is not waiting for. At most one read is outstanding at a time. The command write also uses valid/ready, and valid is held with steady data until it is accepted. An abandon input drops a run in progress without reporting a result. The next start then begins from a fresh first pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: During and straight after reset, busy, done, error, err_timeout, rd_req_valid and wr_valid are all 0.
- R2: A start pulse while idle raises busy in the next cycle. busy stays high until the cycle in which done pulses or an abandon takes effect. A start while busy has no effect.
- R3: Each pair consists of two read requests. A request's rd_req_valid is held until rd_req_ready is seen, and the next request is raised only after the previous response has arrived.
- R4: If bit 6 of the two reads in a pair is equal, done pulses with error low and no command write is made. done comes two cycles after the edge that takes the second response.
- R5: If bit 6 differs and bit 5 of the pair's second read is 0, a new pair starts. Its first request is raised two cycles after the edge that takes the second response.
- R6: If bit 6 differs and bit 5 of the second read is 1, exactly one re-check pair follows. If bit 6 is equal across that re-check pair, the result is success (done with error low).
- R7: If bit 6 still differs in the re-check pair, wr_valid rises with wr_data = RESET_CMD (default 0xF0) and is held until wr_ready. In the cycle after that handshake, done and error pulse with err_timeout low.
- R8: If the MAX_PAIRS-th pair would otherwise lead to another pair, done, error and err_timeout pulse together and no command write is made.
- R9: abandon while busy returns the block to idle on the next edge and drops any pending request or write. No done follows. A later start begins with a new first pair and a cleared re-check state and pair count.
- R10: done, error and err_timeout are one-cycle pulses. error and err_timeout are never high without done, and busy is low whenever done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (taken while idle) |
| abandon | input | 1 | Drop the run in progress without a result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | With done: the run failed |
| err_timeout | output | 1 | With error: the pair limit was reached |
| rd_req_valid | output | 1 | Status read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DATA_W | Read data (status byte) |
| wr_valid | output | 1 | Command write valid |
| wr_ready | input | 1 | Command write accepted |
| wr_data | output | DATA_W | Command write data (RESET_CMD) |

## Verification
The checker watches every cycle for the handshake rules: a held read request, a held and steady command write, and a read and a write never issued together. It also checks the pulse shape of done, error and err_timeout, the rule that busy falls only at done or at an abandon, and the idle outputs after reset. Which outcome a run reaches cannot be judged from one cycle. The success after a re-check, the failure write, the pair limit, the ignored mid-run start and the fresh restart after an abandon are shown only by the bench's status sequences. Those runs use randomized ready and response delays and are compared against a reference model on every clock.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // controller phase
  typedef enum logic [1:0] {
    T_IDLE  = 2'd0,
    T_POLL  = 2'd1,
    T_WRITE = 2'd2
  } ctl_st_t;

  // pair reader phase
  typedef enum logic [2:0] {
    P_IDLE = 3'd0,
    P_REQ1 = 3'd1,
    P_RSP1 = 3'd2,
    P_REQ2 = 3'd3,
    P_RSP2 = 3'd4
  } pair_st_t;

endpackage

// File: rtl/tpc_pair_reader.sv
module tpc_pair_reader
  import tpc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TOG_BIT  = 6,
  parameter int FLAG_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              flush,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              pair_done,
  output logic              toggled,
  output logic              flag
);

  pair_st_t st;
  logic     first_tog;

  assign rd_req_valid = (st == P_REQ1) || (st == P_REQ2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= P_IDLE;
      first_tog <= 1'b0;
      pair_done <= 1'b0;
      toggled   <= 1'b0;
      flag      <= 1'b0;
    end else begin
      pair_done <= 1'b0;
      if (flush) begin
        st <= P_IDLE;
      end else begin
        case (st)
          P_IDLE: if (kick) st <= P_REQ1;
          P_REQ1: if (rd_req_ready) st <= P_RSP1;
          P_RSP1: if (rsp_valid) begin
            first_tog <= rsp_data[TOG_BIT];
            st        <= P_REQ2;
          end
          P_REQ2: if (rd_req_ready) st <= P_RSP2;
          P_RSP2: if (rsp_valid) begin
            toggled   <= rsp_data[TOG_BIT] ^ first_tog;
            flag      <= rsp_data[FLAG_BIT];
            pair_done <= 1'b1;
            st        <= P_IDLE;
          end
          default: st <= P_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/tpc_pair_counter.sv
module tpc_pair_counter #(
  parameter int MAX_PAIRS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);

  localparam int CW = $clog2(MAX_PAIRS + 1);

  logic [CW-1:0] cnt;

  // the pair now finishing is the last one allowed
  assign at_last = (cnt == CW'(MAX_PAIRS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tpc_cmd_writer.sv
module tpc_cmd_writer #(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              flush,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              sent
);

  assign wr_data = wr_valid ? CMD : '0;
  assign sent    = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_valid <= 1'b0;
    else if (flush) wr_valid <= 1'b0;
    else if (load)  wr_valid <= 1'b1;
    else if (sent)  wr_valid <= 1'b0;
  end

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpc_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                TOG_BIT   = 6,
  parameter int                FLAG_BIT  = 5,
  parameter int                MAX_PAIRS = 1024,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abandon,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              err_timeout,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data
);

  ctl_st_t st;
  logic    recheck;
  logic    pair_done, toggled, flag, at_last, sent;
  logic    launch, eval, ok, fail, tmo, cont;
  logic    kick, flush, ctr_inc;

  assign busy   = (st != T_IDLE);
  assign flush  = abandon && busy;
  assign launch = (st == T_IDLE) && start;
  assign eval   = (st == T_POLL) && pair_done && !abandon;
  assign ok     = !toggled;
  assign fail   = toggled && recheck;
  assign tmo    = toggled && !recheck && at_last;
  assign cont   = toggled && !recheck && !at_last;

  assign kick    = launch || (eval && cont);
  assign ctr_inc = eval && cont;

  tpc_pair_reader #(
    .DATA_W  (DATA_W),
    .TOG_BIT (TOG_BIT),
    .FLAG_BIT(FLAG_BIT)
  ) u_reader (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick        (kick),
    .flush       (flush),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .pair_done   (pair_done),
    .toggled     (toggled),
    .flag        (flag)
  );

  tpc_pair_counter #(
    .MAX_PAIRS(MAX_PAIRS)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (launch),
    .inc    (ctr_inc),
    .at_last(at_last)
  );

  tpc_cmd_writer #(
    .DATA_W(DATA_W),
    .CMD   (RESET_CMD)
  ) u_writer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (eval && fail),
    .flush   (flush),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_data (wr_data),
    .sent    (sent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= T_IDLE;
      recheck     <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done        <= 1'b0;
      error       <= 1'b0;
      err_timeout <= 1'b0;
      if (flush) begin
        st <= T_IDLE;
      end else begin
        case (st)
          T_IDLE: if (start) begin
            st      <= T_POLL;
            recheck <= 1'b0;
          end
          T_POLL: if (eval) begin
            if (ok) begin
              st   <= T_IDLE;
              done <= 1'b1;
            end else if (fail) begin
              st <= T_WRITE;
            end else if (tmo) begin
              st          <= T_IDLE;
              done        <= 1'b1;
              error       <= 1'b1;
              err_timeout <= 1'b1;
            end else begin
              recheck <= flag;
            end
          end
          T_WRITE: if (sent) begin
            st    <= T_IDLE;
            done  <= 1'b1;
            error <= 1'b1;
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abandon,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              err_timeout,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data
);

  // R1: outputs quiet as reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !done && !error && !err_timeout && !rd_req_valid && !wr_valid);

  // R2: busy only drops on completion or abandon
  a_r2_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done || $past(abandon));

  // R3: read request held until accepted
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready && !abandon |=> rd_req_valid);

  // R3: never read and write at once
  a_r3_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  // R7: command write held and steady until accepted
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !abandon |=> wr_valid && $stable(wr_data));

  // R10: pulse shapes
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done && !busy);

  // R8: timeout flag only on an error
  a_r8_tmo_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> error);

endmodule

bind toggle_poll_ctrl tpc_checker #(.DATA_W(DATA_W)) u_tpc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .abandon     (abandon),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .err_timeout (err_timeout),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_data     (wr_data)
);

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, abandon = 1'b0;
  logic       busy, done, error, err_timeout;
  logic       rd_req_valid, rd_req_ready = 1'b0;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic       wr_valid, wr_ready = 1'b0;
  logic [7:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_poll_ctrl #(.MAX_PAIRS(MAXP)) i_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abandon(abandon),
    .busy(busy), .done(done), .error(error), .err_timeout(err_timeout),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
  );

  int errors = 0, checks = 0, cycles = 0;
  int n_done = 0, n_err = 0, n_to = 0, n_wr = 0, n_reads = 0;
  int pend = 0;
  int rdy_pct = 70;
  logic [7:0] sq[$];

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // reference model, updated on each rising edge
  int ph = 0;               // 0 idle 1 req1 2 rsp1 3 req2 4 rsp2 5 eval 6 write
  bit m_b6, m_tog, m_flag, m_re;
  int m_pairs;
  bit e_done, e_err, e_to;

  always @(posedge clk) begin
    cycles++;
    e_done = 0; e_err = 0; e_to = 0;
    if (!rst_n) begin
      ph = 0; m_re = 0; m_pairs = 0;
    end else if (abandon && ph != 0) begin
      ph = 0;
    end else begin
      case (ph)
        0: if (start) begin ph = 1; m_re = 0; m_pairs = 0; end
        1: if (rd_req_ready) ph = 2;
        2: if (rsp_valid) begin m_b6 = rsp_data[6]; ph = 3; end
        3: if (rd_req_ready) ph = 4;
        4: if (rsp_valid) begin m_tog = rsp_data[6] != m_b6; m_flag = rsp_data[5]; ph = 5; end
        5: begin
          m_pairs++;
          if (!m_tog) begin ph = 0; e_done = 1; end
          else if (m_re) ph = 6;
          else if (m_pairs == MAXP) begin ph = 0; e_done = 1; e_err = 1; e_to = 1; end
          else begin m_re = m_flag; ph = 1; end
        end
        6: if (wr_ready) begin ph = 0; e_done = 1; e_err = 1; end
        default: ph = 0;
      endcase
    end
  end

  // compare, then drive the device side
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (ph != 0), "R2 busy", busy, ph != 0);
      chk(rd_req_valid == (ph == 1 || ph == 3), "R3 rd_req_valid", rd_req_valid, ph == 1 || ph == 3);
      chk(wr_valid == (ph == 6), "R7 wr_valid", wr_valid, ph == 6);
      chk(done == e_done, "R10 done", done, e_done);
      chk(error == e_err, "R10 error", error, e_err);
      chk(err_timeout == e_to, "R8 err_timeout", err_timeout, e_to);
      if (done) n_done++;
      if (error) n_err++;
      if (err_timeout) n_to++;
    end
    rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = (sq.size() > 0) ? sq.pop_front() : 8'h40;
      end
    end
    rd_req_ready = ($urandom_range(99) < rdy_pct);
    wr_ready     = ($urandom_range(99) < rdy_pct);
    if (rst_n && !abandon && rd_req_valid && rd_req_ready) begin
      n_reads++;
      pend = $urandom_range(3, 1);
    end
    if (rst_n && !abandon && wr_valid && wr_ready) begin
      n_wr++;
      chk(wr_data == 8'hF0, "R7 wr_data", wr_data, 8'hF0);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_counts();
    n_done = 0; n_err = 0; n_to = 0; n_wr = 0; n_reads = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (n_done == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic outcome(input string tag, input int d, input int e, input int to, input int w, input int r);
    chk(n_done == d, {tag, " done count"}, n_done, d);
    chk(n_err == e, {tag, " error count"}, n_err, e);
    chk(n_to == to, {tag, " timeout count"}, n_to, to);
    chk(n_wr == w, {tag, " write count"}, n_wr, w);
    chk(n_reads == r, {tag, " read count"}, n_reads, r);
  endtask

  initial begin : watchdog
    while (cycles < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!busy && !done && !error && !err_timeout && !rd_req_valid && !wr_valid,
        "R1 outputs in reset", {busy, done, error, rd_req_valid, wr_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req_valid && !wr_valid, "R1 idle after reset", {busy, rd_req_valid, wr_valid}, 0);

    // R4: immediate stop
    clear_counts(); sq = {8'h40, 8'h40};
    pulse_start(); wait_done();
    outcome("R4", 1, 0, 0, 0, 2);

    // R5 + R2: toggling with flag low, extra start while busy ignored
    clear_counts(); sq = {8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'h40};
    pulse_start(); repeat (4) @(negedge clk); pulse_start(); wait_done();
    outcome("R5 R2", 1, 0, 0, 0, 6);

    // R6: flag high, re-check pair stops toggling
    clear_counts(); sq = {8'h00, 8'h60, 8'h20, 8'h20};
    pulse_start(); wait_done();
    outcome("R6", 1, 0, 0, 0, 4);

    // R7: flag high, re-check pair keeps toggling, slow write ready
    clear_counts(); sq = {8'h00, 8'h60, 8'h20, 8'h60}; rdy_pct = 30;
    pulse_start(); wait_done(); rdy_pct = 70;
    outcome("R7", 1, 1, 0, 1, 4);

    // R8: pair limit
    clear_counts(); sq = {};
    for (int i = 0; i < 2*MAXP; i++) sq.push_back((i % 2) ? 8'h40 : 8'h00);
    pulse_start(); wait_done();
    outcome("R8", 1, 1, 1, 0, 2*MAXP);

    // R9: abandon after the flag sets re-check, then restart fresh
    clear_counts(); sq = {8'h00, 8'h60};
    pulse_start();
    while (n_reads < 3) @(negedge clk);
    abandon = 1'b1; @(negedge clk); abandon = 1'b0;
    pend = 0;
    repeat (6) @(negedge clk);
    chk(n_done == 0, "R9 no done after abandon", n_done, 0);
    chk(!busy && !rd_req_valid, "R9 idle after abandon", {busy, rd_req_valid}, 0);
    clear_counts(); sq = {8'h00, 8'h40, 8'h40, 8'h40};
    pulse_start(); wait_done();
    outcome("R9 restart", 1, 0, 0, 0, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule